// File: doc/BRIEF.md
# Egress VLAN Tag Editor

This block sits on the egress side of a switch port and edits each outgoing Ethernet frame as a byte stream. Depending on the egress port's control bits and on sideband data sent with the frame, it does one of three things. It can add a four-byte 802.1Q tag after the twelve address bytes. It can delete an existing tag at that position. Or it passes the frame through unchanged. When it adds or removes a tag, it discards the frame's original check sequence and appends a freshly computed one.

The input stream carries the complete frame, including its original four-byte FCS. The frame has first-byte and last-byte markers and uses valid/ready flow control. The ingress port number and an "already tagged" flag are presented together with the first byte. The inserted tag uses the fixed protocol identifier 0x8100, followed by the ingress port's default tag control word taken from a flat per-port bank. Insertion happens only when that ingress port's bit is set in the egress port's source mask. A four-byte delay line holds back the tail of the frame, so the original check bytes can be recognised when the end marker arrives. While added bytes go out, the input is stalled.

Top module: `vlan_tag_editor`

## Requirements
- R1: With insertion on, the frame flagged untagged and the ingress port's mask bit set, the output is the 12 address bytes, then 0x81, 0x00, the control word high byte then low byte, then the remaining body bytes, then a new FCS.
- R2: A frame flagged as tagged is never given a second tag: with insertion on and removal off, it leaves byte-for-byte unchanged.
- R3: If the ingress port's bit in `cfg_src_mask` is clear, no tag is added and the frame leaves unchanged.
- R4: With removal on, a frame flagged as tagged loses input bytes 12 to 15, and a new FCS is appended.
- R5: With removal on and insertion off, a frame flagged untagged leaves unchanged.
- R6: A regenerated FCS is the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones, result inverted) over all output bytes before it. It is sent least significant byte first.
- R7: An unedited frame keeps its four received trailer bytes exactly, even when they are not a valid CRC.
- R8: The inserted control word is the slice `cfg_def_tci[16*p +: 16]`, where p is `s_src_port` sampled with the first byte.
- R9: While `m_valid` is high and `m_ready` low, `m_data`, `m_sof` and `m_eof` stay unchanged and no byte is lost.
- R10: Each output frame asserts `m_sof` only on its first byte and `m_eof` only on its last byte.
- R11: After reset, `m_valid` is low and `s_ready` is high.
- R12: With both insertion and removal on, tagged frames are stripped and untagged frames from a selected port are tagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted |
| s_data | input | 8 | Input byte |
| s_sof | input | 1 | First byte of a frame |
| s_eof | input | 1 | Last byte of a frame (last FCS byte) |
| s_src_port | input | PW | Ingress port number, valid with the first byte |
| s_tagged | input | 1 | Frame already carries a tag, valid with the first byte |
| cfg_ins_en | input | 1 | Egress port allows tag insertion |
| cfg_rm_en | input | 1 | Egress port strips tags |
| cfg_src_mask | input | NPORTS | Ingress ports whose default tag may be inserted |
| cfg_def_tci | input | 16*NPORTS | Default tag control word per ingress port |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the output byte |
| m_data | output | 8 | Output byte |
| m_sof | output | 1 | First output byte of a frame |
| m_eof | output | 1 | Last output byte of a frame |

## Verification
The properties assume an orderly source, which the stimulus tasks follow:
- Once `s_valid` is raised, it and the byte stay put until `s_ready` is seen.
- The sideband fields and the configuration stay constant for the whole frame.
- `s_tagged` agrees with bytes 12 and 13 of the frame.
- Every frame is long enough that its trailer lies beyond the tag position (at least 18 bytes untagged, 22 tagged).

The sweep covers every ingress port, every control-bit combination, both tag states and a set or cleared mask bit. It varies payload lengths and the validity of the received FCS, and on some frames it holds back `m_ready` irregularly.

// File: rtl/vlan_tag_editor.sv
module vlan_tag_editor #(
  parameter int NPORTS = 5,
  parameter logic [15:0] TPID = 16'h8100,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [7:0]             s_data,
  input  logic                   s_sof,
  input  logic                   s_eof,
  input  logic [PW-1:0]          s_src_port,
  input  logic                   s_tagged,
  input  logic                   cfg_ins_en,
  input  logic                   cfg_rm_en,
  input  logic [NPORTS-1:0]      cfg_src_mask,
  input  logic [16*NPORTS-1:0]   cfg_def_tci,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic [7:0]             m_data,
  output logic                   m_sof,
  output logic                   m_eof
);
  localparam int HDR = 12;
  localparam int IW = $clog2(HDR + 5);
  localparam logic [IW-1:0] IMAX = IW'(HDR + 4);
  localparam logic [31:0] RPOLY = 32'hEDB88320;

  typedef enum logic [1:0] {ST_BODY, ST_TAG, ST_TRL} st_t;

  st_t             st;
  logic [3:0][7:0] dly;
  logic [2:0]      dcnt;
  logic [IW-1:0]   ridx;
  logic [1:0]      k;
  logic [31:0]     crc;
  logic            mode_ins, mode_rm;
  logic [15:0]     tci_q;
  logic [15:0]     sel_tci;
  logic            sel_ok;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ RPOLY) : (r >> 1);
    return r;
  endfunction

  always_comb begin
    sel_tci = '0;
    sel_ok  = 1'b0;
    for (int p = 0; p < NPORTS; p++)
      if (s_src_port == PW'(p)) begin
        sel_tci = cfg_def_tci[16*p +: 16];
        sel_ok  = cfg_src_mask[p];
      end
  end

  wire full  = (dcnt == 3'd4);
  wire drop  = mode_rm && (ridx >= IW'(HDR)) && (ridx < IMAX);
  wire regen = mode_ins | mode_rm;
  wire [31:0] fcs = ~crc;
  wire [7:0] tag_byte = (k == 2'd0) ? TPID[15:8] : (k == 2'd1) ? TPID[7:0] :
                        (k == 2'd2) ? tci_q[15:8] : tci_q[7:0];
  wire [7:0] trl_byte = regen ? fcs[8*k +: 8] : dly[k];

  always_comb begin
    s_ready = 1'b0;
    m_valid = 1'b0;
    m_data  = dly[0];
    m_sof   = 1'b0;
    m_eof   = 1'b0;
    case (st)
      ST_BODY: begin
        s_ready = !full || drop || m_ready;
        m_valid = s_valid && full && !drop;
        m_sof   = (ridx == '0);
      end
      ST_TAG: begin
        m_valid = 1'b1;
        m_data  = tag_byte;
      end
      default: begin
        m_valid = 1'b1;
        m_data  = trl_byte;
        m_eof   = (k == 2'd3);
      end
    endcase
  end

  wire acc = s_valid && s_ready;
  wire mo  = m_valid && m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_BODY;
      dly      <= '0;
      dcnt     <= '0;
      ridx     <= '0;
      k        <= '0;
      crc      <= '1;
      mode_ins <= 1'b0;
      mode_rm  <= 1'b0;
      tci_q    <= '0;
    end else begin
      case (st)
        ST_BODY: if (acc) begin
          if (s_sof) begin
            mode_ins <= cfg_ins_en && !s_tagged && sel_ok;
            mode_rm  <= cfg_rm_en && s_tagged;
            tci_q    <= sel_tci;
          end
          if (full) begin
            dly <= {s_data, dly[3], dly[2], dly[1]};
            if (ridx != IMAX) ridx <= ridx + 1'b1;
            if (!drop) crc <= crc_step(crc, dly[0]);
            if (mode_ins && ridx == IW'(HDR - 1) && !s_eof) begin
              st <= ST_TAG;
              k  <= '0;
            end
          end else begin
            dly[dcnt[1:0]] <= s_data;
            dcnt <= dcnt + 1'b1;
          end
          if (s_eof) begin
            st <= ST_TRL;
            k  <= '0;
          end
        end
        ST_TAG: if (mo) begin
          crc <= crc_step(crc, tag_byte);
          k   <= k + 1'b1;
          if (k == 2'd3) st <= ST_BODY;
        end
        default: if (mo) begin
          k <= k + 1'b1;
          if (k == 2'd3) begin
            st   <= ST_BODY;
            dcnt <= '0;
            ridx <= '0;
            crc  <= '1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vlan_tag_editor_chk.sv
module vlan_tag_editor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_ready,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_sof,
  input logic       m_eof
);
  logic in_frame;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) in_frame <= 1'b0;
    else if (m_valid && m_ready) in_frame <= !m_eof;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_eof));

  p_marks_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !(m_sof && m_eof));

  p_sof_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_sof == !in_frame));

  p_trailer_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_eof |-> !s_ready);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !m_valid && s_ready);
endmodule

bind vlan_tag_editor vlan_tag_editor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_sof(m_sof), .m_eof(m_eof));

// File: tb/vlan_tag_editor_tb_top.sv
module vlan_tag_editor_tb_top;
  localparam int NP = 5;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0, s_tagged = 1'b0;
  logic [7:0] s_data = '0;
  logic [PW-1:0] s_src_port = '0;
  logic cfg_ins_en = 1'b0, cfg_rm_en = 1'b0;
  logic [NP-1:0] cfg_src_mask = '1;
  logic [16*NP-1:0] cfg_def_tci;
  logic m_ready = 1'b1;
  logic s_ready, m_valid, m_sof, m_eof;
  logic [7:0] m_data;

  always #10 clk = ~clk;

  vlan_tag_editor #(.NPORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_eof(s_eof), .s_src_port(s_src_port), .s_tagged(s_tagged),
    .cfg_ins_en(cfg_ins_en), .cfg_rm_en(cfg_rm_en), .cfg_src_mask(cfg_src_mask),
    .cfg_def_tci(cfg_def_tci), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sof(m_sof), .m_eof(m_eof));

  int checks = 0, failures = 0, cyc = 0, frames_done = 0, gotn = 0;
  logic bp = 1'b0;
  logic [7:0] inb [0:127];
  logic [7:0] exb [0:127];
  logic [7:0] gotb [0:127];
  logic gsof [0:127];
  logic geof [0:127];
  int inlen, exlen;

  function automatic logic [15:0] tci_of(input int p);
    return 16'h3000 | 16'(p * 16'h0123);
  endfunction

  function automatic logic [31:0] crc_add(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always begin
    @(negedge clk);
    #1 m_ready = bp ? (($urandom % 3) != 0) : 1'b1;
    #4;
    if (rst_n && m_valid && m_ready) begin
      gotb[gotn] = m_data;
      gsof[gotn] = m_sof;
      geof[gotn] = m_eof;
      gotn++;
      if (m_eof) frames_done++;
    end
  end

  task automatic build(input int src, input bit tg, input int plen, input bit bad,
                       input bit ins, input bit rm);
    logic [31:0] c;
    int n;
    n = 0;
    for (int i = 0; i < 12; i++) begin inb[n] = 8'((8'h10 + i * 3) ^ src); n++; end
    if (tg) begin
      inb[n] = 8'h81; inb[n+1] = 8'h00; inb[n+2] = 8'h2F; inb[n+3] = 8'(8'h5A ^ plen); n += 4;
    end
    inb[n] = 8'h08; inb[n+1] = 8'h00; n += 2;
    for (int i = 0; i < plen; i++) begin inb[n] = 8'(i * 7 + src); n++; end
    c = '1;
    for (int i = 0; i < n; i++) c = crc_add(c, inb[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) inb[n+i] = c[8*i +: 8];
    if (bad) inb[n] = inb[n] ^ 8'hA5;
    inlen = n + 4;
    exlen = 0;
    if (ins || rm) begin
      for (int i = 0; i < 12; i++) begin exb[exlen] = inb[i]; exlen++; end
      if (ins) begin
        exb[exlen] = 8'h81; exb[exlen+1] = 8'h00;
        exb[exlen+2] = tci_of(src)[15:8]; exb[exlen+3] = tci_of(src)[7:0]; exlen += 4;
      end
      for (int i = rm ? 16 : 12; i < n; i++) begin exb[exlen] = inb[i]; exlen++; end
      c = '1;
      for (int i = 0; i < exlen; i++) c = crc_add(c, exb[i]);
      c = ~c;
      for (int i = 0; i < 4; i++) exb[exlen+i] = c[8*i +: 8];
      exlen += 4;
    end else begin
      for (int i = 0; i < inlen; i++) exb[i] = inb[i];
      exlen = inlen;
    end
  endtask

  task automatic send(input int src, input bit tg);
    int target;
    target = frames_done + 1;
    gotn = 0;
    for (int i = 0; i < inlen; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = inb[i]; s_sof = (i == 0); s_eof = (i == inlen - 1);
      s_src_port = PW'(src); s_tagged = tg;
      forever begin
        #2;
        if (s_ready) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    while (frames_done != target) @(negedge clk);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) cfg_def_tci[16*p +: 16] = tci_of(p);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    check(!m_valid, "R11", "m_valid after reset", int'(m_valid), 0);
    check(s_ready, "R11", "s_ready after reset", int'(s_ready), 1);
    for (int src = 0; src < NP; src++)
      for (int cfg = 0; cfg < 4; cfg++)
        for (int tg = 0; tg < 2; tg++)
          for (int ms = 0; ms < 2; ms++) begin
            bit ins, rm, edit, bad, lenok, dataok, markok;
            int plen, bidx;
            string req;
            plen = 3 + ((src * 7 + cfg * 3 + tg + ms * 5) % 20);
            bad = ((src + cfg + ms) % 2) == 1;
            cfg_ins_en = cfg[0];
            cfg_rm_en = cfg[1];
            cfg_src_mask = ms ? ~(NP'(1) << src) : '1;
            bp = ((src + tg + ms) % 2) == 1;
            ins = cfg[0] && !tg && (ms == 0);
            rm = cfg[1] && tg;
            edit = ins || rm;
            if (cfg == 3 && edit) req = "R12";
            else if (ins) req = "R1";
            else if (rm) req = "R4";
            else if (tg && cfg[0]) req = "R2";
            else if (!tg && cfg[0]) req = "R3";
            else if (!tg && cfg[1]) req = "R5";
            else req = "R7";
            if (bp) req = {req, " R9"};
            build(src, tg[0], plen, bad, ins, rm);
            send(src, tg[0]);
            lenok = (gotn == exlen);
            check(lenok, req, "frame length", gotn, exlen);
            dataok = 1'b1; bidx = 0;
            markok = 1'b1;
            for (int i = 0; i < exlen && i < gotn; i++) begin
              if (dataok && gotb[i] !== exb[i]) begin dataok = 1'b0; bidx = i; end
              if (gsof[i] !== (i == 0) || geof[i] !== (i == exlen - 1)) markok = 1'b0;
            end
            check(dataok, req, $sformatf("byte %0d", bidx), int'(gotb[bidx]), int'(exb[bidx]));
            check(markok && lenok, "R10", "sof/eof placement", int'(markok), 1);
            if (edit && lenok)
              check({gotb[exlen-1], gotb[exlen-2], gotb[exlen-3], gotb[exlen-4]} ===
                    {exb[exlen-1], exb[exlen-2], exb[exlen-3], exb[exlen-4]}, "R6", "new FCS",
                    int'({gotb[exlen-1], gotb[exlen-2], gotb[exlen-3], gotb[exlen-4]}),
                    int'({exb[exlen-1], exb[exlen-2], exb[exlen-3], exb[exlen-4]}));
            if (!edit && bad && lenok)
              check(gotb[exlen-4] === inb[inlen-4], "R7", "kept bad FCS byte",
                    int'(gotb[exlen-4]), int'(inb[inlen-4]));
            if (ins && lenok)
              check({gotb[14], gotb[15]} === tci_of(src), "R8", "inserted control word",
                    int'({gotb[14], gotb[15]}), int'(tci_of(src)));
          end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule